// File: doc/BRIEF.md
# Two-Wire Serial Byte Memory Slave with Random Read

This block is a slave on a two-wire serial bus (I2C) that holds a 2048 x 8 byte store in on-chip registers. SCL and SDA are taken in through a synchroniser clocked by the system clock. The block finds START, repeated START and STOP conditions and decodes a device-select byte. Bits 7..4 of that byte must equal a fixed device type, bits 3..1 carry the three most significant memory address bits, and bit 0 gives the transfer direction.

A host sets the block's internal address pointer with a write transfer: the device-select byte, then a word-address byte holding the low eight address bits. To read a byte at any address, the host then issues a repeated START, sends a device-select byte with the read direction, and receives the byte. The host can keep reading consecutive bytes by acknowledging each one, and ends the read by leaving the acknowledge bit high and sending STOP. A byte sent after the word address in a write transfer is stored, so the store can be loaded.

SDA is open-drain. The block never drives it high. It asserts a pull-low enable when it acknowledges a byte or sends a 0 data bit.

Top module: `i2c_mem_slave`

## Requirements
- R1: While reset is asserted, and right after it is released, the pull-low enable `sda_oe` is 0.
- R2: The block acknowledges a device-select byte only when its bits 7..4 are 1010: it pulls SDA low during the ninth clock. Any other value gets no acknowledge, and every byte that follows is ignored until the next START. Ignored bytes get no acknowledge and write nothing.
- R3: In a write transfer (select bit 0 = 0), the block acknowledges the next byte. It loads the address pointer with select bits 3..1 as address bits 10..8 and that byte as address bits 7..0.
- R4: In a write transfer, a byte that follows the word address is acknowledged and stored at the pointer. The pointer then advances by one.
- R5: A device-select byte with bit 0 = 1, sent after a repeated START, is acknowledged. The block then shifts out the byte at the pointer, bit 7 first, one bit per SCL clock.
- R6: When the host acknowledges a data byte (SDA low on the ninth clock), the block sends the byte at the next address.
- R7: When the host leaves SDA high on the ninth clock of a read byte, the block releases SDA and drives it on no later clock until a new START.
- R8: A STOP returns the block to idle with SDA released. Bytes clocked in before the next START get no acknowledge.
- R9: `sda_oe` changes only while SCL is low.
- R10: A read transfer that sends no word address starts at the location after the last byte that was read or written.
- R11: The address pointer wraps from 2047 to 0.
- R12: Select bits 3..1 of a read device-select byte do not affect which byte is returned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; it must run at least 8 times faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus (wired-AND level) |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |

## Verification
The bench builds the block with its default parameters: an 11-bit address, device type 1010 and a two-stage synchroniser. With these values the full 2048-byte space is in use. An address sweep in steps of 97 visits all eight values of the upper three bits. The addresses at both ends of the space are used, so the 2047-to-0 wrap is reachable. Expected bytes come from a closed-form pattern of the address. A pin-level monitor compares every change of the pull-low enable against the SCL level.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,      // waiting for START
    ST_RX,        // shifting in a byte from the host
    ST_ACK_PRE,   // byte complete, pull SDA at next SCL low
    ST_ACK_HOLD,  // holding ACK, release or load data at next SCL low
    ST_TX,        // shifting a byte out
    ST_MACK_PRE,  // byte out done, release SDA at next SCL low
    ST_MACK,      // sampling host acknowledge
    ST_WAIT       // ignoring the bus until START
  } st_t;

  typedef enum logic [1:0] {
    K_DEV,
    K_ADDR,
    K_DATA
  } kind_t;

endpackage

// File: rtl/i2cm_sync.sv
module i2cm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic start_ev,
  output logic stop_ev,
  output logic scl_rise,
  output logic scl_fall
);

  logic [STAGES-1:0] scl_c;
  logic [STAGES-1:0] sda_c;
  logic              scl_q;
  logic              sda_q;

  // synchroniser chain, idle bus level on reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_c <= '1;
      sda_c <= '1;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_c <= {scl_c[STAGES-2:0], scl_i};
      sda_c <= {sda_c[STAGES-2:0], sda_i};
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_s    = scl_c[STAGES-1];
  assign sda_s    = sda_c[STAGES-1];
  assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;

endmodule

// File: rtl/i2cm_mem.sv
module i2cm_mem #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];

  // data storage carries no reset
  always_ff @(posedge clk) begin
    if (we) begin
      store[addr] <= wdata;
    end
  end

  assign rdata = store[addr];

endmodule

// File: rtl/i2cm_ctrl.sv
module i2cm_ctrl
  import i2cm_pkg::*;
#(
  parameter int         AW     = 11,
  parameter logic [3:0] DEV_ID = 4'b1010
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_ev,
  input  logic          stop_ev,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          sda_s,
  input  logic [7:0]    rdata,
  output logic          sda_oe,
  output logic          mem_we,
  output logic [7:0]    mem_wdata,
  output logic [AW-1:0] ptr,
  output logic          in_idle
);

  // AW must lie in 9..11: the upper bits ride in select bits 3..1
  localparam int            HW  = AW - 8;
  localparam logic [AW-1:0] ONE = 1;

  st_t            st_q,   st_d;
  kind_t          kind_q, kind_d;
  logic [2:0]     cnt_q,  cnt_d;
  logic [7:0]     sh_q,   sh_d;
  logic [AW-1:0]  ptr_q,  ptr_d;
  logic [HW-1:0]  hi_q,   hi_d;
  logic           rd_q,   rd_d;
  logic           oe_q,   oe_d;
  logic [7:0]     rx_byte;

  assign rx_byte = {sh_q[6:0], sda_s};

  always_comb begin
    st_d   = st_q;
    kind_d = kind_q;
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    ptr_d  = ptr_q;
    hi_d   = hi_q;
    rd_d   = rd_q;
    oe_d   = oe_q;
    mem_we = 1'b0;
    if (start_ev) begin
      st_d   = ST_RX;
      kind_d = K_DEV;
      cnt_d  = '0;
      oe_d   = 1'b0;
    end else if (stop_ev) begin
      st_d = ST_IDLE;
      oe_d = 1'b0;
    end else begin
      case (st_q)
        ST_RX: begin
          if (scl_rise) begin
            sh_d  = rx_byte;
            cnt_d = cnt_q + 3'd1;
            if (cnt_q == 3'd7) begin
              st_d = ST_ACK_PRE;
              case (kind_q)
                K_DEV: begin
                  if (rx_byte[7:4] == DEV_ID) begin
                    rd_d = rx_byte[0];
                    if (!rx_byte[0]) begin
                      hi_d = rx_byte[HW:1];
                    end
                  end else begin
                    st_d = ST_WAIT;
                  end
                end
                K_ADDR: begin
                  ptr_d = {hi_q, rx_byte};
                end
                default: begin
                  mem_we = 1'b1;
                  ptr_d  = ptr_q + ONE;
                end
              endcase
            end
          end
        end
        ST_ACK_PRE: begin
          if (scl_fall) begin
            oe_d = 1'b1;
            st_d = ST_ACK_HOLD;
          end
        end
        ST_ACK_HOLD: begin
          if (scl_fall) begin
            cnt_d = '0;
            if (kind_q == K_DEV && rd_q) begin
              sh_d  = rdata;
              oe_d  = ~rdata[7];
              ptr_d = ptr_q + ONE;
              st_d  = ST_TX;
            end else begin
              oe_d   = 1'b0;
              st_d   = ST_RX;
              kind_d = (kind_q == K_DEV) ? K_ADDR : K_DATA;
            end
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            cnt_d = cnt_q + 3'd1;
            if (cnt_q == 3'd7) begin
              st_d = ST_MACK_PRE;
            end
          end else if (scl_fall) begin
            sh_d = {sh_q[6:0], 1'b0};
            oe_d = ~sh_q[6];
          end
        end
        ST_MACK_PRE: begin
          if (scl_fall) begin
            oe_d = 1'b0;
            st_d = ST_MACK;
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            st_d = sda_s ? ST_WAIT : ST_ACK_HOLD;
          end
        end
        default: begin
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      kind_q <= K_DEV;
      cnt_q  <= '0;
      sh_q   <= '0;
      ptr_q  <= '0;
      hi_q   <= '0;
      rd_q   <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      kind_q <= kind_d;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      ptr_q  <= ptr_d;
      hi_q   <= hi_d;
      rd_q   <= rd_d;
      oe_q   <= oe_d;
    end
  end

  assign sda_oe    = oe_q;
  assign mem_wdata = rx_byte;
  assign ptr       = ptr_q;
  assign in_idle   = (st_q == ST_IDLE);

endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave #(
  parameter int         AW          = 11,
  parameter logic [3:0] DEV_ID      = 4'b1010,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);

  logic          rst_meta;
  logic          rst_q;
  logic          scl_s;
  logic          sda_s;
  logic          start_ev;
  logic          stop_ev;
  logic          scl_rise;
  logic          scl_fall;
  logic          mem_we;
  logic [7:0]    mem_wdata;
  logic [7:0]    mem_rdata;
  logic [AW-1:0] ptr;
  logic          in_idle;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  i2cm_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk      (clk),
    .rst_n    (rst_q),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .start_ev (start_ev),
    .stop_ev  (stop_ev),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall)
  );

  i2cm_ctrl #(.AW(AW), .DEV_ID(DEV_ID)) i_ctrl (
    .clk       (clk),
    .rst_n     (rst_q),
    .start_ev  (start_ev),
    .stop_ev   (stop_ev),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .sda_s     (sda_s),
    .rdata     (mem_rdata),
    .sda_oe    (sda_oe),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .ptr       (ptr),
    .in_idle   (in_idle)
  );

  i2cm_mem #(.AW(AW), .DW(8)) i_mem (
    .clk   (clk),
    .we    (mem_we),
    .addr  (ptr),
    .wdata (mem_wdata),
    .rdata (mem_rdata)
  );

endmodule

// File: rtl/i2cm_chk.sv
module i2cm_chk #(
  parameter int AW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sda_oe,
  input logic          scl_s,
  input logic          start_ev,
  input logic          stop_ev,
  input logic          mem_we,
  input logic [AW-1:0] ptr,
  input logic          in_idle
);

  AST_OE_ONLY_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s); // R9

  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !sda_oe); // R8

  AST_START_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> !sda_oe); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle |-> !sda_oe); // R8

  AST_WRITE_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> ptr == $past(ptr) + 1'b1); // R4

  AST_PTR_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && ptr == '1) |=> ptr == '0); // R11

endmodule

bind i2c_mem_slave i2cm_chk #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_q),
  .sda_oe   (sda_oe),
  .scl_s    (scl_s),
  .start_ev (start_ev),
  .stop_ev  (stop_ev),
  .mem_we   (mem_we),
  .ptr      (ptr),
  .in_idle  (in_idle)
);

// File: tb/test_i2c_mem_slave.sv
module test_i2c_mem_slave;

  localparam int HP = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic m_scl;
  logic m_sda;
  logic sda_oe;
  wire  sda_line = m_sda & ~sda_oe;

  int   total = 0;
  int   bad = 0;
  bit   done = 0;
  logic [7:0] model [2048];
  logic oe_prev = 1'b0;
  int   r9_bad = 0;

  always #2 clk = ~clk;

  i2c_mem_slave i_i2c_mem_slave (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_i  (m_scl),
    .sda_i  (sda_line),
    .sda_oe (sda_oe)
  );

  // pin-level watch on SDA drive changes (R9)
  always @(posedge clk) begin
    if (rst_n === 1'b1 && sda_oe !== oe_prev && m_scl === 1'b1) r9_bad++;
    oe_prev <= sda_oe;
  end

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) ^ (a >> 3));
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hp(input int n = HP);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start();
    m_sda = 1'b1; hp();
    m_scl = 1'b1; hp();
    m_sda = 1'b0; hp();
    m_scl = 1'b0; hp(2);
  endtask

  task automatic do_stop();
    m_sda = 1'b0; hp();
    m_scl = 1'b1; hp();
    m_sda = 1'b1; hp();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; hp();
      m_scl = 1'b1; hp();
      m_scl = 1'b0; hp(2);
    end
    m_sda = 1'b1; hp();
    m_scl = 1'b1; hp(4);
    ack = (sda_line == 1'b0);
    hp(4);
    m_scl = 1'b0; hp(2);
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] d);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hp();
      m_scl = 1'b1; hp(4);
      d[i] = sda_line;
      hp(4);
      m_scl = 1'b0; hp(2);
    end
    m_sda = mack ? 1'b0 : 1'b1; hp();
    m_scl = 1'b1; hp();
    m_scl = 1'b0; hp(2);
    m_sda = 1'b1;
  endtask

  // one extra SCL pulse after a NACK: SDA must stay high (R7)
  task automatic idle_pulse_r7();
    hp();
    m_scl = 1'b1; hp(4);
    chk(sda_line == 1'b1, "R7 released after NACK", sda_line, 1);
    hp(4);
    m_scl = 1'b0; hp(2);
  endtask

  task automatic write_byte(input int a, input logic [7:0] d);
    bit ack;
    do_start();
    send_byte({4'b1010, 3'(a >> 8), 1'b0}, ack);
    chk(ack, "R2 select acked", ack, 1);
    send_byte(8'(a), ack);
    chk(ack, "R3 word address acked", ack, 1);
    send_byte(d, ack);
    chk(ack, "R4 data acked", ack, 1);
    do_stop();
    model[a] = d;
  endtask

  // dummy write of the address, repeated START, read with given select bits
  task automatic rand_read_start(input int a, input logic [2:0] rd_hi);
    bit ack;
    do_start();
    send_byte({4'b1010, 3'(a >> 8), 1'b0}, ack);
    chk(ack, "R3 select acked", ack, 1);
    send_byte(8'(a), ack);
    chk(ack, "R3 word address acked", ack, 1);
    do_start();
    send_byte({4'b1010, rd_hi, 1'b1}, ack);
    chk(ack, "R5 read select acked", ack, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    bit ack;
    m_scl = 1'b1;
    m_sda = 1'b1;
    rst_n = 1'b0;
    hp(5);
    chk(sda_oe == 1'b0, "R1 reset drive", sda_oe, 0);
    rst_n = 1'b1;
    hp(5);
    chk(sda_oe == 1'b0, "R1 after reset", sda_oe, 0);

    // fill sweep over the whole space, all upper-bit values
    for (int a = 0; a < 2048; a += 97) write_byte(a, pat(a));
    write_byte(2047, pat(2047));
    write_byte(500, pat(500));
    write_byte(501, pat(501));
    write_byte(502, pat(502));
    write_byte(12'h220, 8'hC3);

    // random reads with NACK
    for (int a = 0; a < 2048; a += 97) begin
      rand_read_start(a, 3'(a >> 8));
      recv_byte(1'b0, d);
      chk(d == model[a], "R5 random read data", d, model[a]);
      idle_pulse_r7();
      do_stop();
    end

    // sequential read with host ACKs
    rand_read_start(500, 3'(500 >> 8));
    recv_byte(1'b1, d);
    chk(d == model[500], "R6 first byte", d, model[500]);
    recv_byte(1'b1, d);
    chk(d == model[501], "R6 second byte", d, model[501]);
    recv_byte(1'b0, d);
    chk(d == model[502], "R6 third byte", d, model[502]);
    idle_pulse_r7();
    do_stop();

    // current-address read after a random read of 500
    rand_read_start(500, 3'(500 >> 8));
    recv_byte(1'b0, d);
    do_stop();
    do_start();
    send_byte({4'b1010, 3'b000, 1'b1}, ack);
    chk(ack, "R10 current read acked", ack, 1);
    recv_byte(1'b0, d);
    chk(d == model[501], "R10 next location", d, model[501]);
    do_stop();

    // wrap: write at 2047 leaves pointer at 0
    write_byte(0, 8'h3C);
    write_byte(2047, 8'hA5);
    do_start();
    send_byte({4'b1010, 3'b111, 1'b1}, ack);
    recv_byte(1'b0, d);
    chk(d == model[0], "R11 wrap to 0", d, model[0]);
    do_stop();

    // wrong device type: no ACK, following bytes ignored
    do_start();
    send_byte({4'b1001, 3'b010, 1'b0}, ack);
    chk(!ack, "R2 foreign type not acked", ack, 0);
    send_byte(8'h20, ack);
    chk(!ack, "R2 ignored address", ack, 0);
    send_byte(8'h5A, ack);
    chk(!ack, "R2 ignored data", ack, 0);
    do_stop();
    rand_read_start(12'h220, 3'b010);
    recv_byte(1'b0, d);
    chk(d == model[12'h220], "R2 no write happened", d, model[12'h220]);
    do_stop();

    // after STOP, bytes without START are not acked
    send_byte({4'b1010, 3'b000, 1'b1}, ack);
    chk(!ack, "R8 no START no ACK", ack, 0);
    chk(sda_oe == 1'b0, "R8 idle released", sda_oe, 0);
    do_stop();

    // read select bits do not matter
    rand_read_start(12'h220, 3'b101);
    recv_byte(1'b0, d);
    chk(d == model[12'h220], "R12 read select bits ignored", d, model[12'h220]);
    do_stop();
    rand_read_start(1067, 3'b000);
    recv_byte(1'b0, d);
    chk(d == model[1067], "R12 read select bits ignored", d, model[1067]);
    do_stop();

    chk(r9_bad == 0, "R9 drive changes with SCL high", r9_bad, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule